// File: doc/BRIEF.md
# Two-Level Turn-Off Sequencer

This block is the clocked controller behind a power-switch gate driver. It decides when the gate is pulled high, held at an intermediate plateau, or pulled low. It also steers the timing-capacitor pins and handles protection events. All analog parts sit outside the block and reach it only as flags: the capacitor threshold comparator, the output-below-reference comparator and the desaturation detector. The block never drives the gate straight from full-on to full-off. Every turn-off passes through a plateau whose length was learned digitally at the last turn-on.

A turn-on starts with a fixed discharge of the timing capacitor, followed by charging until the threshold comparator trips. The block counts the clock cycles of this whole interval and stores the count. At turn-off it drives the gate down until the output reaches the reference. It then holds the plateau for the stored number of cycles and only after that drives fully low. Because both delays come from the same count, an on command shorter than that interval never switches the gate on. An off command shorter than the plateau leaves the gate returning high at the end of the plateau. Repeated returns of that kind are cut off after a set number. A desaturation trip forces a turn-off after its own fixed delay and locks the gate off until the command is withdrawn.

Top module: `tlto_sequencer`

## Requirements
- R1: After reset, only `driveLow` is asserted. `driveHigh`, `drivePlateau`, `capDischarge` and `capCharge` are low. The stored plateau count is zero.
- R2: When an allowed on command is seen in idle, `capDischarge` is asserted for exactly DISCH_CYCLES cycles. Then `capCharge` is asserted until `capAboveThr` is sampled high. Let K be the number of charge cycles up to and including that sample. `driveHigh` rises DISCH_CYCLES+K+2 cycles after the command is first sampled, with one all-drives-off cycle in between.
- R3: The stored plateau count equals the number of cycles spent discharging plus charging, including the cycle in which `capAboveThr` is sampled. The count saturates at 2^CNT_W-1 and does not wrap.
- R4: A turn-off is handled in this order. First one gap cycle. Then `driveLow` until `outBelowRef` is sampled high. Then one gap cycle. Then `drivePlateau` for the stored count of cycles, or one cycle if the count is zero. Then one gap cycle, and finally `driveLow`.
- R5: A `desatTrip` pulse while the gate is high keeps `driveHigh` asserted for exactly DESAT_DLY more cycles, then runs the R4 turn-off. The gate then stays off while `cmdOn` remains high.
- R6: If the on command is withdrawn during discharge or charge, the block returns to idle. `driveHigh` is never asserted and both capacitor controls drop.
- R7: A plateau, once started, always runs its full length. If the on command is present when it ends, the sequence is a gap cycle and then `driveHigh`, with no discharge or charge phase.
- R8: The plateau may return the gate high SHORT_LIMIT-1 times in a row. The next plateau ends in `driveLow` even with `cmdOn` high, and the gate stays off until `cmdOn` is deasserted. A completed turn-on or a normal full turn-off resets the run count.
- R9: At most one of `driveHigh`, `drivePlateau` and `driveLow` is asserted in any cycle. Between any two different drive states there is at least one cycle with none asserted.
- R10: `capDischarge` and `capCharge` are never asserted together. Either one is asserted only while `driveLow` is asserted.
- R11: `shutdown` high blocks any turn-on. When the gate is high, `shutdown` starts the R4 turn-off on the next clock edge, regardless of `cmdOn`.
- R12: Every fall of `driveHigh` is followed by the low-drive phase of R4. Every plateau is preceded by that phase; no path skips the plateau.
- R13: `desatTrip` has no effect while the gate is not high. A later turn-on proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (one tick is the 50 ns timing step) |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOn | input | 1 | Qualified on/off command, high requests gate on |
| shutdown | input | 1 | Enable-off request, high forces gate off |
| desatTrip | input | 1 | Desaturation detected pulse |
| capAboveThr | input | 1 | Timing capacitor above charge threshold |
| outBelowRef | input | 1 | Gate output has fallen below plateau reference |
| driveHigh | output | 1 | Enable for the pull-up stage |
| drivePlateau | output | 1 | Enable for the plateau regulation stage |
| driveLow | output | 1 | Enable for the pull-down stage |
| capDischarge | output | 1 | Discharge the timing capacitor |
| capCharge | output | 1 | Charge the timing capacitor |

## Verification
All outputs are decoded from the state register, so each changes one clock after the input sample that causes it. Turn-on reaches `driveHigh` DISCH_CYCLES+K+2 cycles after the command. Turn-off goes to its gap cycle on the first edge after `cmdOn` or `shutdown` changes, while a desaturation trip adds DESAT_DLY cycles of held high drive. The plateau begins two cycles after `outBelowRef` is sampled. The bench drives all inputs on falling edges and samples on the following falling edges. It counts sampled cycles of each output (discharge, plateau, held-high, turn-on latency) rather than waiting for fixed times, so each count compares directly with the cycle numbers above.

// File: rtl/tlto_pkg.sv
package tlto_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DISCH,
    S_CHARGE,
    S_GHIGH,
    S_HIGH,
    S_DSWAIT,
    S_GFALL,
    S_FALL,
    S_GPLAT,
    S_PLAT,
    S_GLOW
  } tlto_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic measClr;
    logic measInc;
    logic storeLoad;
    logic platLoad;
    logic platInc;
    logic dsLoad;
    logic dsInc;
    logic shortInc;
    logic shortClr;
  } tlto_strb_t;

endpackage

// File: rtl/tlto_dp.sv
module tlto_dp
  import tlto_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int DISCH_CYCLES = 10,
  parameter int DESAT_DLY    = 4,
  parameter int SHORT_LIMIT  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  tlto_strb_t strb,
  output logic       dischDone,
  output logic       platDone,
  output logic       dsDone,
  output logic       shortLast
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int DS_W = $clog2(DESAT_DLY + 1);
  localparam int SH_W = $clog2(SHORT_LIMIT + 1);

  logic [CNT_W-1:0] measCnt;
  logic [CNT_W-1:0] storedT;
  logic [CNT_W-1:0] platCnt;
  logic [DS_W-1:0]  dsCnt;
  logic [SH_W-1:0]  shortCnt;

  // turn-on interval counter, also times the discharge phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                measCnt <= '0;
    else if (strb.measClr)                    measCnt <= CNT_W'(1);
    else if (strb.measInc && measCnt != CNT_MAX) measCnt <= measCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               storedT <= '0;
    else if (strb.storeLoad) storedT <= measCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              platCnt <= '0;
    else if (strb.platLoad) platCnt <= CNT_W'(1);
    else if (strb.platInc)  platCnt <= platCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dsCnt <= '0;
    else if (strb.dsLoad) dsCnt <= DS_W'(1);
    else if (strb.dsInc)  dsCnt <= dsCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shortCnt <= '0;
    else if (strb.shortClr)  shortCnt <= '0;
    else if (strb.shortInc)  shortCnt <= shortCnt + 1'b1;
  end

  assign dischDone = (measCnt >= CNT_W'(DISCH_CYCLES));
  assign platDone  = (platCnt >= storedT);
  assign dsDone    = (dsCnt >= DS_W'(DESAT_DLY));
  assign shortLast = (shortCnt >= SH_W'(SHORT_LIMIT - 1));

  // R3: the interval count holds at its ceiling
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.measInc && !strb.measClr && measCnt == CNT_MAX) |=> (measCnt == CNT_MAX));

  // R4: the plateau never runs past the stored length
  p_plat_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.platInc |-> (platCnt < storedT));

endmodule

// File: rtl/tlto_ctrl.sv
module tlto_ctrl
  import tlto_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdOn,
  input  logic       shutdown,
  input  logic       desatTrip,
  input  logic       capAboveThr,
  input  logic       outBelowRef,
  input  logic       dischDone,
  input  logic       platDone,
  input  logic       dsDone,
  input  logic       shortLast,
  output tlto_strb_t strb,
  output logic       driveHigh,
  output logic       drivePlateau,
  output logic       driveLow,
  output logic       capDischarge,
  output logic       capCharge
);

  tlto_state_t state, stateNxt;
  logic inhibit;
  logic setInhibit;
  logic extOn;
  logic onReq;

  assign extOn = cmdOn && !shutdown;
  assign onReq = extOn && !inhibit;

  always_comb begin
    stateNxt   = state;
    strb       = '0;
    setInhibit = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (onReq) begin
          stateNxt     = S_DISCH;
          strb.measClr = 1'b1;
        end
      end
      S_DISCH: begin
        if (!onReq) stateNxt = S_IDLE;
        else begin
          strb.measInc = 1'b1;
          if (dischDone) stateNxt = S_CHARGE;
        end
      end
      S_CHARGE: begin
        if (!onReq) stateNxt = S_IDLE;
        else if (capAboveThr) begin
          stateNxt       = S_GHIGH;
          strb.storeLoad = 1'b1;
          strb.shortClr  = 1'b1;
        end else strb.measInc = 1'b1;
      end
      S_GHIGH: stateNxt = S_HIGH;
      S_HIGH: begin
        if (!onReq) stateNxt = S_GFALL;
        else if (desatTrip) begin
          stateNxt    = S_DSWAIT;
          strb.dsLoad = 1'b1;
          setInhibit  = 1'b1;
        end
      end
      S_DSWAIT: begin
        if (!extOn || dsDone) stateNxt = S_GFALL;
        else strb.dsInc = 1'b1;
      end
      S_GFALL: stateNxt = S_FALL;
      S_FALL: begin
        if (outBelowRef) begin
          stateNxt      = S_GPLAT;
          strb.platLoad = 1'b1;
        end
      end
      S_GPLAT: stateNxt = S_PLAT;
      S_PLAT: begin
        if (!platDone) strb.platInc = 1'b1;
        else if (onReq && !shortLast) begin
          stateNxt      = S_GHIGH;
          strb.shortInc = 1'b1;
        end else begin
          stateNxt      = S_GLOW;
          strb.shortClr = 1'b1;
          setInhibit    = onReq;
        end
      end
      S_GLOW:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           inhibit <= 1'b0;
    else if (setInhibit) inhibit <= 1'b1;
    else if (!cmdOn)     inhibit <= 1'b0;
  end

  assign driveHigh    = (state == S_HIGH) || (state == S_DSWAIT);
  assign drivePlateau = (state == S_PLAT);
  assign driveLow     = (state == S_IDLE) || (state == S_DISCH) ||
                        (state == S_CHARGE) || (state == S_FALL);
  assign capDischarge = (state == S_DISCH);
  assign capCharge    = (state == S_CHARGE);

  p_drive_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({driveHigh, drivePlateau, driveLow}));

  p_gap_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |=> (driveHigh || !(drivePlateau || driveLow)));

  p_gap_plat_r9: assert property (@(posedge clk) disable iff (!rstN)
    drivePlateau |=> (drivePlateau || !(driveHigh || driveLow)));

  p_gap_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |=> (driveLow || !(driveHigh || drivePlateau)));

  p_cap_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(capDischarge && capCharge));

  p_cap_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (capDischarge || capCharge) |-> driveLow);

  p_shut_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (driveHigh && shutdown) |=> !driveHigh);

  p_fall_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveHigh) |=> driveLow);

  p_plat_after_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drivePlateau) |-> $past(driveLow, 2));

endmodule

// File: rtl/tlto_sequencer.sv
module tlto_sequencer
  import tlto_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int DISCH_CYCLES = 10,
  parameter int DESAT_DLY    = 4,
  parameter int SHORT_LIMIT  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdOn,
  input  logic shutdown,
  input  logic desatTrip,
  input  logic capAboveThr,
  input  logic outBelowRef,
  output logic driveHigh,
  output logic drivePlateau,
  output logic driveLow,
  output logic capDischarge,
  output logic capCharge
);

  tlto_strb_t strb;
  logic dischDone, platDone, dsDone, shortLast;

  tlto_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cmdOn        (cmdOn),
    .shutdown     (shutdown),
    .desatTrip    (desatTrip),
    .capAboveThr  (capAboveThr),
    .outBelowRef  (outBelowRef),
    .dischDone    (dischDone),
    .platDone     (platDone),
    .dsDone       (dsDone),
    .shortLast    (shortLast),
    .strb         (strb),
    .driveHigh    (driveHigh),
    .drivePlateau (drivePlateau),
    .driveLow     (driveLow),
    .capDischarge (capDischarge),
    .capCharge    (capCharge)
  );

  tlto_dp #(
    .CNT_W        (CNT_W),
    .DISCH_CYCLES (DISCH_CYCLES),
    .DESAT_DLY    (DESAT_DLY),
    .SHORT_LIMIT  (SHORT_LIMIT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dischDone (dischDone),
    .platDone  (platDone),
    .dsDone    (dsDone),
    .shortLast (shortLast)
  );

endmodule

// File: tb/tlto_sequencer_tb.sv
module tlto_sequencer_tb_top;

  localparam int CNT_W  = 8;
  localparam int DISCH  = 10;
  localparam int DSDLY  = 4;
  localparam int SHORTL = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int VEC_N  = 5;
  // charge cycles K for each vector; expected count = DISCH+K (saturated)
  localparam int VEC_K [VEC_N] = '{1, 5, 20, 40, 250};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdOn = 1'b0, shutdown = 1'b0, desatTrip = 1'b0;
  logic capAboveThr = 1'b0, outBelowRef = 1'b0;
  logic driveHigh, drivePlateau, driveLow, capDischarge, capCharge;

  int checks = 0;
  int fails = 0;
  int gapErr = 0;
  int gapSeen = 0;
  logic [2:0] prevDrv = 3'b000;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlto_sequencer #(
    .CNT_W(CNT_W), .DISCH_CYCLES(DISCH), .DESAT_DLY(DSDLY), .SHORT_LIMIT(SHORTL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cmdOn(cmdOn), .shutdown(shutdown),
    .desatTrip(desatTrip), .capAboveThr(capAboveThr), .outBelowRef(outBelowRef),
    .driveHigh(driveHigh), .drivePlateau(drivePlateau), .driveLow(driveLow),
    .capDischarge(capDischarge), .capCharge(capCharge)
  );

  // drive-state monitor for R9
  always @(negedge clk) begin
    if (rstN) begin
      if (!$onehot0({driveHigh, drivePlateau, driveLow})) gapErr++;
      if (prevDrv != 3'b000 && {driveHigh, drivePlateau, driveLow} != 3'b000 &&
          {driveHigh, drivePlateau, driveLow} != prevDrv) gapErr++;
      if (prevDrv != 3'b000 && {driveHigh, drivePlateau, driveLow} == 3'b000) gapSeen++;
      prevDrv = {driveHigh, drivePlateau, driveLow};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic turn_on(input int k, output int lat, output int disc);
    int chg;
    lat = 0; disc = 0; chg = 0;
    cmdOn = 1'b1;
    while (!driveHigh && lat < 2000) begin
      @(negedge clk);
      lat++;
      if (capDischarge) disc++;
      if (capCharge) begin
        chg++;
        if (chg == k) capAboveThr = 1'b1;
      end
    end
    capAboveThr = 1'b0;
  endtask

  // from the first low-drive phase of a turn-off, count plateau cycles
  task automatic finish_off(output int plat, output int capAct, output bit backHigh);
    plat = 0; capAct = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (drivePlateau) plat++;
      if (capDischarge || capCharge) capAct++;
      if (driveLow && plat == 0) outBelowRef = 1'b1;
      if (plat > 0 && !drivePlateau && (driveHigh || driveLow)) break;
    end
    backHigh = driveHigh;
    outBelowRef = 1'b0;
  endtask

  task automatic turn_off(output int plat);
    int ca;
    bit bh;
    cmdOn = 1'b0;
    finish_off(plat, ca, bh);
  endtask

  task automatic off_pulse(output int plat, output int capAct, output bit backHigh);
    cmdOn = 1'b0;
    @(negedge clk);
    cmdOn = 1'b1;
    finish_off(plat, capAct, backHigh);
  endtask

  initial begin
    int lat, disc, plat, ca, hi, seenHigh, seenCap;
    bit bh;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 driveLow at reset", int'(driveLow), 1);
    chk("R1 other outputs at reset",
        int'({driveHigh, drivePlateau, capDischarge, capCharge}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'({driveHigh, drivePlateau, driveLow}), 1);

    // table walk: R2 latency and discharge, R3/R4 plateau length
    for (int v = 0; v < VEC_N; v++) begin
      int expCnt;
      expCnt = (DISCH + VEC_K[v] > CMAX) ? CMAX : DISCH + VEC_K[v];
      turn_on(VEC_K[v], lat, disc);
      chk("R2 turn-on latency", lat, DISCH + VEC_K[v] + 2);
      chk("R2 discharge cycles", disc, DISCH);
      repeat (3) @(negedge clk);
      turn_off(plat);
      chk("R3 R4 plateau cycles", plat, expCnt);
      chk("R4 ends in low drive", int'({driveHigh, drivePlateau, driveLow}), 1);
    end

    // R6: on pulse shorter than the turn-on interval
    cmdOn = 1'b1;
    seenHigh = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (driveHigh) seenHigh++;
    end
    cmdOn = 1'b0;
    @(negedge clk);
    chk("R6 short on pulse never drives high", seenHigh, 0);
    chk("R6 capacitor controls released", int'({capDischarge, capCharge}), 0);
    chk("R6 low drive kept", int'(driveLow), 1);

    // R13: desat while off ignored
    desatTrip = 1'b1;
    @(negedge clk);
    desatTrip = 1'b0;
    @(negedge clk);
    turn_on(2, lat, disc);
    chk("R13 turn-on after idle desat", lat, DISCH + 4);

    // R7: short off pulses; R8: the run limit
    off_pulse(plat, ca, bh);
    chk("R7 plateau full length (1st)", plat, DISCH + 2);
    chk("R7 back high (1st)", int'(bh), 1);
    chk("R7 no capacitor cycle on return", ca, 0);
    off_pulse(plat, ca, bh);
    chk("R7 back high (2nd)", int'(bh), 1);
    off_pulse(plat, ca, bh);
    chk("R8 third return forced low", int'(bh), 0);
    chk("R8 forced plateau full length", plat, DISCH + 2);
    seenHigh = 0; seenCap = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (driveHigh) seenHigh++;
      if (capDischarge) seenCap++;
    end
    chk("R8 held off while cmdOn high", seenHigh + seenCap, 0);
    cmdOn = 1'b0;
    repeat (2) @(negedge clk);
    turn_on(3, lat, disc);
    chk("R8 turn-on after command release", lat, DISCH + 5);

    // R11: shutdown from high
    shutdown = 1'b1;
    @(negedge clk);
    chk("R11 shutdown drops high next cycle", int'({driveHigh, drivePlateau, driveLow}), 0);
    turn_off(plat);
    chk("R11 R12 shutdown turn-off has plateau", plat, DISCH + 3);
    cmdOn = 1'b1;
    seenCap = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (capDischarge || driveHigh) seenCap++;
    end
    chk("R11 shutdown blocks turn-on", seenCap, 0);
    shutdown = 1'b0;
    cmdOn = 1'b0;
    @(negedge clk);

    // R5: desaturation trip while high
    turn_on(5, lat, disc);
    repeat (2) @(negedge clk);
    hi = 0;
    desatTrip = 1'b1;
    @(negedge clk);
    desatTrip = 1'b0;
    while (driveHigh && hi < 100) begin
      hi++;
      @(negedge clk);
    end
    chk("R5 high held for desat delay", hi, DSDLY);
    finish_off(plat, ca, bh);
    chk("R5 desat turn-off plateau", plat, DISCH + 5);
    seenHigh = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (driveHigh || capDischarge) seenHigh++;
    end
    chk("R5 latched off while cmdOn high", seenHigh, 0);
    cmdOn = 1'b0;
    repeat (2) @(negedge clk);

    chk("R9 drive one-hot with gaps", gapErr, 0);
    chk("R9 gap cycles observed", int'(gapSeen > 10), 1);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule